// File: doc/BRIEF.md
# Memory Protection Configuration Register File

This block stores the configuration and address registers that a hart's physical memory protection unit consults. Software reaches them through a simple register access port. The port carries an address, write data, an access enable and a write enable. Reads are combinational: whatever register `csr_addr` selects appears on `csr_rdata`. The block does not check memory accesses against the regions. It only holds the regions and keeps them legal.

The number of implemented entries, `NUM_ENTRIES`, may be anything from zero to `MAX_ENTRIES`.
- Entries at or above the implemented count can still be addressed, but they read as zero and hold nothing.
- With no entries at all, every access to the protection registers is refused and flagged as illegal.

On top of this storage the block applies three rules:
- Per-entry lock rules, including a lock that reaches back to guard the address register of the entry below.
- Legalization of the permission and mode fields.
- A one-cycle translation-flush strobe after each address-register write.

Top module: `pmp_regfile`

## Requirements
- R1: After reset with at least one implemented entry, entry 0 holds an address of all ones (masked as in R7) and configuration byte 0x1F. That byte means read, write and execute permitted, mode NAPOT and unlocked. Every other entry holds zero.
- R2: Configuration register `CFG_BASE+k` (k < MAX_ENTRIES/4) packs XLEN/8 consecutive entries starting at entry 4k. Entry 4k+j occupies bits 8j+7:8j. Address register `ADDR_BASE+i` holds entry i. `csr_rdata` always shows the register selected by `csr_addr`.
- R3: A configuration byte keeps R (bit 0), W (bit 1), X (bit 2), mode (bits 4:3: OFF=0, TOR=1, NA4=2, NAPOT=3) and L (bit 7). Bits 6:5 are stored and read as zero.
- R4: A configuration byte written with W=1 and R=0 is stored with W cleared.
- R5: An entry whose L bit is set ignores writes to its configuration byte and to its address register until the next reset.
- R6: The address register of entry i ignores writes while entry i+1 is locked with mode TOR. A locked entry i+1 in any other mode does not guard entry i.
- R7: Address registers store only the low PADDR_BITS−2 bits of the written value. Higher bits read as zero.
- R8: Entries with index at or above NUM_ENTRIES read as zero and ignore writes, but accessing them is not illegal.
- R9: With NUM_ENTRIES = 0, all writes are ignored and all protection registers read zero. `csr_illegal` is high in the same cycle as any enabled access to a configuration or address register. `csr_illegal` stays low for disabled accesses and for addresses outside both ranges.
- R10: With NUM_ENTRIES > 0, an enabled write to any address register in range raises `tlb_flush` for exactly the next cycle. This holds even when the write is ignored. Configuration writes and out-of-range writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Register access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| csr_illegal | output | 1 | Access refused (no entries implemented) |
| tlb_flush | output | 1 | One-cycle strobe after an address-register write |

## Verification
The hardest state to reach from the ports is an unlocked entry sitting directly below a locked TOR entry. Locking is itself a write, and a locked byte can never be undone without reset. The stimulus therefore first writes a packed configuration word that locks only the upper entry in TOR mode and leaves its neighbour open. It then writes the neighbour's address register. A second word repeats this with NAPOT mode to show the guard is mode specific. A further instance built with zero entries runs alongside on the same stimulus to exercise the refusal path.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } pmp_amode_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] resv;
      pmp_amode_e mode;
      logic       x;
      logic       w;
      logic       r;
   } pmp_cfg_t;

   localparam pmp_cfg_t CFG_OPEN = '{lock: 1'b0, resv: 2'b00, mode: AM_NAPOT,
                                     x: 1'b1, w: 1'b1, r: 1'b1};

   // Drop reserved bits and the write-without-read combination.
   function automatic pmp_cfg_t cfg_legalize(input logic [7:0] raw);
      pmp_cfg_t c;
      c      = pmp_cfg_t'(raw);
      c.resv = 2'b00;
      if (c.w && !c.r) c.w = 1'b0;
      return c;
   endfunction

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode #(
   parameter int MAX_ENTRIES = 16,
   parameter int CFG_BASE    = 'h3A0,
   parameter int ADDR_BASE   = 'h3B0,
   parameter int IW          = 4,
   parameter int CW          = 2
) (
   input  logic [11:0]   addr,
   output logic          cfg_hit,
   output logic [CW-1:0] cfg_idx,
   output logic          addr_hit,
   output logic [IW-1:0] addr_idx
);
   localparam int NCFG = MAX_ENTRIES / 4;

   logic [11:0] cfg_off;
   logic [11:0] addr_off;

   assign cfg_off  = addr - 12'(CFG_BASE);
   assign addr_off = addr - 12'(ADDR_BASE);

   assign cfg_hit  = cfg_off < 12'(NCFG);
   assign addr_hit = addr_off < 12'(MAX_ENTRIES);
   assign cfg_idx  = cfg_off[CW-1:0];
   assign addr_idx = addr_off[IW-1:0];

   logic unused_hi;
   assign unused_hi = ^{cfg_off[11:CW], addr_off[11:IW]};

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
   import pmp_pkg::*;
#(
   parameter int AW       = 30,
   parameter bit IMPL     = 1'b1,
   parameter bit RST_OPEN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [7:0]    cfg_wbyte,
   input  logic          addr_we,
   input  logic [AW-1:0] addr_wdata,
   input  logic          next_guard,
   output pmp_cfg_t      cfg_q,
   output logic [AW-1:0] addr_q
);

   if (IMPL) begin : g_impl
      pmp_cfg_t      cfg_r;
      logic [AW-1:0] addr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_r  <= RST_OPEN ? CFG_OPEN : pmp_cfg_t'(8'h00);
            addr_r <= RST_OPEN ? {AW{1'b1}} : {AW{1'b0}};
         end else begin
            if (cfg_we && !cfg_r.lock)
               cfg_r <= cfg_legalize(cfg_wbyte);
            if (addr_we && !cfg_r.lock && !next_guard)
               addr_r <= addr_wdata;
         end
      end

      assign cfg_q  = cfg_r;
      assign addr_q = addr_r;
   end else begin : g_tied
      assign cfg_q  = pmp_cfg_t'(8'h00);
      assign addr_q = '0;

      logic unused_in;
      assign unused_in = ^{clk, rst_n, cfg_we, cfg_wbyte, addr_we, addr_wdata, next_guard};
   end

endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile
   import pmp_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int MAX_ENTRIES = 16,
   parameter int NUM_ENTRIES = 6,
   parameter int PADDR_BITS  = 32,
   parameter int CFG_BASE    = 'h3A0,
   parameter int ADDR_BASE   = 'h3B0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_en,
   input  logic            csr_we,
   input  logic [11:0]     csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            csr_illegal,
   output logic            tlb_flush
);
   localparam int AW   = PADDR_BITS - 2;
   localparam int BPW  = XLEN / 8;
   localparam int NCFG = MAX_ENTRIES / 4;
   localparam int IW   = $clog2(MAX_ENTRIES);
   localparam int CW   = (NCFG > 1) ? $clog2(NCFG) : 1;
   localparam int LW   = $clog2(BPW);

   // Elaboration-time parameter checks
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("XLEN must be 32 or 64");
   end
   if (MAX_ENTRIES < 4 || MAX_ENTRIES > 64 || (MAX_ENTRIES % 4) != 0) begin : g_bad_max
      $error("MAX_ENTRIES must be a multiple of 4 in 4..64");
   end
   if (NUM_ENTRIES < 0 || NUM_ENTRIES > MAX_ENTRIES) begin : g_bad_num
      $error("NUM_ENTRIES must lie in 0..MAX_ENTRIES");
   end
   if (AW < 1 || AW > XLEN) begin : g_bad_aw
      $error("PADDR_BITS-2 must lie in 1..XLEN");
   end

   logic          cfg_hit;
   logic [CW-1:0] cfg_idx;
   logic          addr_hit;
   logic [IW-1:0] addr_idx;

   pmp_csr_decode #(
      .MAX_ENTRIES(MAX_ENTRIES),
      .CFG_BASE   (CFG_BASE),
      .ADDR_BASE  (ADDR_BASE),
      .IW         (IW),
      .CW         (CW)
   ) u_dec (
      .addr    (csr_addr),
      .cfg_hit (cfg_hit),
      .cfg_idx (cfg_idx),
      .addr_hit(addr_hit),
      .addr_idx(addr_idx)
   );

   // With no entries, writes never reach storage.
   logic wr_go;
   assign wr_go = csr_en && csr_we && (NUM_ENTRIES != 0);

   logic [7:0] lane_byte [BPW];
   for (genvar l = 0; l < BPW; l++) begin : g_lane
      assign lane_byte[l] = csr_wdata[8*l +: 8];
   end

   pmp_cfg_t         cfg_q  [MAX_ENTRIES];
   logic [AW-1:0]    addr_q [MAX_ENTRIES];
   logic [MAX_ENTRIES-1:0] tor_guard;

   for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
      logic          cfg_sel;
      logic [LW-1:0] lane;
      logic [7:0]    wbyte;
      int            base;

      always_comb begin
         base    = int'(cfg_idx) * 4;
         cfg_sel = cfg_hit && (i >= base) && (i < base + BPW);
         lane    = LW'(i - base);
         wbyte   = lane_byte[lane];
      end

      // Guard from the entry above: locked and top-of-range.
      if (i + 1 < MAX_ENTRIES) begin : g_guard
         assign tor_guard[i] = cfg_q[i+1].lock && (cfg_q[i+1].mode == AM_TOR);
      end else begin : g_top
         assign tor_guard[i] = 1'b0;
      end

      pmp_entry #(
         .AW      (AW),
         .IMPL    (i < NUM_ENTRIES),
         .RST_OPEN(i == 0)
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (wr_go && cfg_sel),
         .cfg_wbyte (wbyte),
         .addr_we   (wr_go && addr_hit && (addr_idx == IW'(i))),
         .addr_wdata(csr_wdata[AW-1:0]),
         .next_guard(tor_guard[i]),
         .cfg_q     (cfg_q[i]),
         .addr_q    (addr_q[i])
      );
   end

   // Combinational read port
   always_comb begin
      csr_rdata = '0;
      if (NUM_ENTRIES != 0) begin
         if (cfg_hit) begin
            for (int k = 0; k < BPW; k++) begin
               if (int'(cfg_idx) * 4 + k < MAX_ENTRIES)
                  csr_rdata[8*k +: 8] = cfg_q[IW'(int'(cfg_idx) * 4 + k)];
            end
         end else if (addr_hit) begin
            csr_rdata = XLEN'(addr_q[addr_idx]);
         end
      end
   end

   if (NUM_ENTRIES == 0) begin : g_none
      assign csr_illegal = csr_en && (cfg_hit || addr_hit);
   end else begin : g_some
      assign csr_illegal = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tlb_flush <= 1'b0;
      else        tlb_flush <= wr_go && addr_hit;
   end

endmodule

// File: rtl/pmp_regfile_chk.sv
module pmp_regfile_chk
   import pmp_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int MAX_ENTRIES = 16,
   parameter int NUM_ENTRIES = 6,
   parameter int PADDR_BITS  = 32,
   parameter int CFG_BASE    = 'h3A0,
   parameter int ADDR_BASE   = 'h3B0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  csr_en,
   input logic                  csr_we,
   input logic [11:0]           csr_addr,
   input logic [XLEN-1:0]       csr_rdata,
   input logic                  csr_illegal,
   input logic                  tlb_flush,
   input pmp_cfg_t              cfg_q  [MAX_ENTRIES],
   input logic [PADDR_BITS-3:0] addr_q [MAX_ENTRIES]
);
   localparam int AW = PADDR_BITS - 2;

   logic in_cfg, in_addr;
   assign in_cfg  = ({20'd0, csr_addr} >= 32'(CFG_BASE)) &&
                    ({20'd0, csr_addr} <  32'(CFG_BASE + MAX_ENTRIES / 4));
   assign in_addr = ({20'd0, csr_addr} >= 32'(ADDR_BASE)) &&
                    ({20'd0, csr_addr} <  32'(ADDR_BASE + MAX_ENTRIES));

   a_r10_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_we && in_addr && NUM_ENTRIES > 0) |=> tlb_flush);

   a_r10_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush |-> $past(csr_en && csr_we && in_addr));

   a_r9_illegal_set: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && (in_cfg || in_addr) && NUM_ENTRIES == 0) |-> csr_illegal);

   a_r9_illegal_only: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_en && NUM_ENTRIES == 0));

   a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      (NUM_ENTRIES == 0) |-> (csr_rdata == '0));

   if (AW < XLEN) begin : g_hi
      a_r7_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_addr && !in_cfg) |-> (csr_rdata[XLEN-1:AW] == '0));
   end

   for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_e
      a_r3_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i].resv == 2'b00);
      a_r4_no_write_only: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_q[i].w && !cfg_q[i].r));
      a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cfg_q[i].lock) |-> (cfg_q[i] == $past(cfg_q[i])));
      a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cfg_q[i].lock) |-> (addr_q[i] == $past(addr_q[i])));
      if (i + 1 < MAX_ENTRIES) begin : g_n
         a_r6_tor_guard: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_q[i+1].lock && cfg_q[i+1].mode == AM_TOR)
               |-> (addr_q[i] == $past(addr_q[i])));
      end
   end

endmodule

bind pmp_regfile pmp_regfile_chk #(
   .XLEN       (XLEN),
   .MAX_ENTRIES(MAX_ENTRIES),
   .NUM_ENTRIES(NUM_ENTRIES),
   .PADDR_BITS (PADDR_BITS),
   .CFG_BASE   (CFG_BASE),
   .ADDR_BASE  (ADDR_BASE)
) u_chk (.*);

// File: tb/sim_pmp_regfile.sv
module sim_pmp_regfile;
   localparam int          N0    = 6;
   localparam int          MAXE  = 16;
   localparam logic [31:0] AMASK = 32'h3FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_en = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = 12'h000;
   logic [31:0] csr_wdata = 32'h0;
   logic [31:0] rd0, rd1;
   logic        ill0, ill1, fl0, fl1;

   int errors = 0;
   int checks = 0;

   typedef struct packed {
      logic [31:0] rd0;
      logic        ill0;
      logic        fl0;
      logic [31:0] rd1;
      logic        ill1;
      logic        fl1;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [7:0]  cfg_m  [MAXE];
   logic [31:0] addr_m [MAXE];
   logic        pend = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pmp_regfile #(.NUM_ENTRIES(N0)) u0 (
      .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rdata(rd0), .csr_illegal(ill0), .tlb_flush(fl0));

   pmp_regfile #(.NUM_ENTRIES(0)) u1 (
      .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rdata(rd1), .csr_illegal(ill1), .tlb_flush(fl1));

   function automatic logic is_cfg(input logic [11:0] a);
      return (a >= 12'h3A0) && (a < 12'h3A4);
   endfunction

   function automatic logic is_addr(input logic [11:0] a);
      return (a >= 12'h3B0) && (a < 12'h3C0);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < MAXE; i++) begin
         cfg_m[i]  = 8'h00;
         addr_m[i] = 32'h0;
      end
      cfg_m[0]  = 8'h1F;
      addr_m[0] = AMASK;
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int o;
      if (is_cfg(a)) begin
         o = int'(a - 12'h3A0) * 4;
         return {cfg_m[o+3], cfg_m[o+2], cfg_m[o+1], cfg_m[o]};
      end
      if (is_addr(a)) return addr_m[int'(a - 12'h3B0)];
      return 32'h0;
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      int o;
      logic [7:0] b;
      if (is_cfg(a)) begin
         o = int'(a - 12'h3A0) * 4;
         for (int j = 0; j < 4; j++) begin
            if (o + j < N0 && !cfg_m[o+j][7]) begin
               b = d[8*j +: 8] & 8'h9F;
               if (b[1] && !b[0]) b[1] = 1'b0;
               cfg_m[o+j] = b;
            end
         end
      end else if (is_addr(a)) begin
         o = int'(a - 12'h3B0);
         if (o < N0 && !cfg_m[o][7] &&
             !(o + 1 < MAXE && cfg_m[o+1][7] && cfg_m[o+1][4:3] == 2'd1))
            addr_m[o] = d & AMASK;
      end
   endtask

   // Driver: applies one access and queues what the monitor should see.
   task automatic op(input logic en, input logic we, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
      e.rd0  = model_read(a);
      e.ill0 = 1'b0;
      e.fl0  = pend;
      e.rd1  = 32'h0;
      e.ill1 = en && (is_cfg(a) || is_addr(a));
      e.fl1  = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      pend = en && we && is_addr(a);
      if (en && we) model_write(a, d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
      pend = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: compares outputs a quarter period after the driving edge.
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "u0 rdata",   rd0,          e.rd0);
            check(t, "u0 illegal", {31'b0, ill0}, {31'b0, e.ill0});
            check(t, "u0 flush",   {31'b0, fl0},  {31'b0, e.fl0});
            check(t, "u1 rdata",   rd1,          e.rd1);
            check(t, "u1 illegal", {31'b0, ill1}, {31'b0, e.ill1});
            check(t, "u1 flush",   {31'b0, fl1},  {31'b0, e.fl1});
         end
      end
   end

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired (all R): actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      op(1, 0, 12'h3A0, 32'h0, "R1 cfg0 after reset");
      op(1, 0, 12'h3B0, 32'h0, "R1 addr0 after reset");
      op(1, 0, 12'h3B1, 32'h0, "R1 addr1 after reset");
      op(1, 0, 12'h3A1, 32'h0, "R1 cfg1 after reset");

      // R10 flush strobe
      op(1, 1, 12'h3B1, 32'h0000_1234, "R10 addr write");
      op(0, 0, 12'h3B1, 32'h0, "R10 strobe high");
      op(0, 0, 12'h3B1, 32'h0, "R10 strobe one cycle");
      op(1, 1, 12'h3A2, 32'hFFFF_FFFF, "R10 cfg write no strobe");
      op(1, 0, 12'h3A2, 32'h0, "R8 cfg2 hardwired zero");

      // R2 packing, R8 entries 6 and 7 hardwired
      op(1, 1, 12'h3A1, 32'hFFFF_1D0B, "R2 cfg1 write");
      op(1, 0, 12'h3A1, 32'h0, "R2 cfg1 packing");

      // R3 field legalization
      op(1, 1, 12'h3A0, 32'h1005_607F, "R3 cfg0 write");
      op(1, 0, 12'h3A0, 32'h0, "R3 reserved bits dropped");

      // R4 W without R
      op(1, 1, 12'h3A0, 32'h0006_0203, "R4 cfg0 write");
      op(1, 0, 12'h3A0, 32'h0, "R4 write-only cleared");

      // R7 address masking
      op(1, 1, 12'h3B2, 32'hFFFF_FFFF, "R7 addr2 write");
      op(1, 0, 12'h3B2, 32'h0, "R7 addr2 masked");
      op(1, 1, 12'h3B3, 32'hC000_1234, "R7 addr3 write");
      op(1, 0, 12'h3B3, 32'h0, "R7 addr3 high bits");

      // R6 locked TOR guards the address below
      op(1, 1, 12'h3A0, 32'h8900_0000, "R6 lock entry3 TOR");
      op(1, 1, 12'h3B2, 32'h0000_0ABC, "R6 guarded write");
      op(1, 0, 12'h3B2, 32'h0, "R6 addr2 unchanged");
      op(1, 1, 12'h3B1, 32'h0000_0555, "R6 unguarded write");
      op(1, 0, 12'h3B1, 32'h0, "R6 addr1 updated");

      // R5 own lock
      op(1, 1, 12'h3B3, 32'h0000_0777, "R5 locked addr write");
      op(1, 0, 12'h3B3, 32'h0, "R5 addr3 unchanged");
      op(1, 1, 12'h3A0, 32'h0000_0000, "R5 cfg0 clear attempt");
      op(1, 0, 12'h3A0, 32'h0, "R5 cfg3 byte kept");

      // R6 locked NAPOT does not guard
      op(1, 1, 12'h3A1, 32'h0000_9800, "R6 lock entry5 NAPOT");
      op(1, 1, 12'h3B4, 32'h0000_0042, "R6 write below NAPOT lock");
      op(1, 0, 12'h3B4, 32'h0, "R6 addr4 updated");
      op(1, 1, 12'h3B5, 32'h0000_0099, "R5 entry5 addr write");
      op(1, 0, 12'h3B5, 32'h0, "R5 addr5 unchanged");
      op(1, 1, 12'h3A1, 32'h0000_0001, "R5 cfg1 rewrite");
      op(1, 0, 12'h3A1, 32'h0, "R5 cfg5 byte kept");

      // R8 unimplemented entries
      op(1, 1, 12'h3B6, 32'h0000_0001, "R8 addr6 write");
      op(1, 0, 12'h3B6, 32'h0, "R8 addr6 zero with strobe");
      op(1, 0, 12'h3BF, 32'h0, "R8 addr15 zero");

      // R9 illegal flag qualifiers, out-of-range access
      op(0, 1, 12'h3A0, 32'hFFFF_FFFF, "R9 disabled access");
      op(1, 1, 12'h3C0, 32'hFFFF_FFFF, "R9 out of range write");
      op(1, 0, 12'h3B4, 32'h0, "R9 no strobe, addr4 intact");

      // R5 locks released by reset
      do_reset();
      op(1, 0, 12'h3A0, 32'h0, "R5 cfg0 after second reset");
      op(1, 0, 12'h3B3, 32'h0, "R1 addr3 after second reset");
      op(1, 1, 12'h3B3, 32'h0000_0321, "R5 addr3 writable again");
      op(1, 0, 12'h3B3, 32'h0, "R5 addr3 updated");
      op(0, 0, 12'h000, 32'h0, "R10 idle");

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule